// File: doc/BRIEF.md
# Timer Event Interrupt and DMA Request Router

This block sits behind a multifunction timer. It gathers five event strobes: one end-of-count, two input captures and two output compares. It latches each strobe in a sticky pending flag and turns the flags into three interrupt request lines with a fixed priority order. Each source has a mask bit that decides whether its flag may reach an interrupt line.

Two of the sources can be served by DMA instead of by an interrupt:

- the capture on capture register 0, on DMA channel 0;
- the match on compare register 0, on DMA channel 1.

While a channel is enabled, a pending flag of its source raises the channel's request and does not reach the interrupt line. The request holds until the channel's acknowledge arrives. That acknowledge clears the flag, so the interrupt never fires for that event.

Software clears flags by writing ones to the acknowledge vector. A strobe that arrives in the same cycle as its clear is kept.

Top module: `tmr_evt_router`

## Requirements

The five source bit positions used by every vector are fixed:

| Bit | Source |
|-----|--------|
| 0 | end of count |
| 1 | capture 0 |
| 2 | capture 1 |
| 3 | compare 0 |
| 4 | compare 1 |

- R1: After a synchronous reset, every pending flag, interrupt line, DMA request, `irq_any_o` and `irq_idx_o` is zero.
- R2: An event strobe on a source sets that source's pending flag on the next clock edge. The flag stays set while no clear reaches it.
- R3: A one in `ack_i` clears the matching pending flag on the next edge. A zero in `ack_i` leaves the matching flag unchanged.
- R4: When an event strobe and a clear for the same source arrive in the same cycle, the flag is set after the edge.
- R5: Events arriving together on several sources in one cycle are all latched at that edge.
- R6: A source whose mask bit is 0 keeps its pending flag but does not drive any interrupt line. Setting the mask later, with the flag still pending, raises the line.
- R7: Line 0 carries end of count (bit 0). Line 1 is the OR of capture 0 and capture 1 (bits 1, 2). Line 2 is the OR of compare 0 and compare 1 (bits 3, 4). A source drives its line only while it is pending, masked in, and not diverted to DMA.
- R8: `irq_idx_o` gives the lowest-numbered active line, with line 0 highest priority. `irq_any_o` is high exactly when some line is active. `irq_idx_o` is 0 when no line is active.
- R9: DMA channel 0 serves capture 0 and channel 1 serves compare 0. While a channel is enabled, its request equals its source's pending flag, and that source is kept off its interrupt line whatever its mask.
- R10: A DMA acknowledge on a channel clears its source's pending flag on the next edge. The request therefore drops without that source ever raising an interrupt.
- R11: If a channel is disabled while its source is still pending, the request drops. The flag then drives its interrupt line if the source is masked in.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | Event strobes, one per source |
| mask_i | input | 5 | Interrupt enable per source |
| ack_i | input | 5 | Write-one-to-clear of pending flags |
| dma_en_i | input | 2 | DMA enable, channel 0 = capture 0, channel 1 = compare 0 |
| dma_ack_i | input | 2 | DMA acknowledge per channel |
| pend_o | output | 5 | Pending flags |
| irq_o | output | 3 | Interrupt request lines |
| irq_any_o | output | 1 | Some interrupt line is active |
| irq_idx_o | output | 2 | Index of highest-priority active line |
| dma_req_o | output | 2 | DMA request per channel |

## Verification

The bench targets these corner cases:

- **Set and clear in one cycle.** A design that lets the clear win drops an event.
- **All five sources firing together.** An encoder-style latch would keep only one of them.
- **Clear of one line while a lower-priority line stays active.** A wrong priority order reports the wrong index.
- **DMA diversion.** A router that ignored the DMA enable would fire both the interrupt and the request for one capture or compare.
- **DMA acknowledge.** A design where the acknowledge only dropped the request would leave a stale interrupt behind.

A behavioural model runs beside the design over directed and random traffic, with masks and DMA enables toggling while flags are pending.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    localparam int NUM_SRC  = 5;
    localparam int NUM_LINE = 3;
    localparam int NUM_DMA  = 2;
    localparam int IDX_W    = $clog2(NUM_LINE);

    localparam int SRC_EOC  = 0;
    localparam int SRC_CAP0 = 1;
    localparam int SRC_CAP1 = 2;
    localparam int SRC_CMP0 = 3;
    localparam int SRC_CMP1 = 4;

    typedef logic [NUM_SRC-1:0]  src_vec_t;
    typedef logic [NUM_LINE-1:0] line_vec_t;
    typedef logic [NUM_DMA-1:0]  dma_vec_t;

    typedef struct packed {
        line_vec_t        req;
        logic             any;
        logic [IDX_W-1:0] idx;
    } irq_bus_t;

    // Source served by each DMA channel.
    function automatic int dma_src(input int ch);
        return (ch == 0) ? SRC_CAP0 : SRC_CMP0;
    endfunction

    // Interrupt line each source feeds.
    function automatic int line_of(input int src);
        if (src == SRC_EOC)                        return 0;
        else if (src == SRC_CAP0 || src == SRC_CAP1) return 1;
        else                                       return 2;
    endfunction

    // Lowest-numbered active line wins.
    function automatic logic [IDX_W-1:0] first_line(input line_vec_t req);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_LINE - 1; i >= 0; i--) begin
            if (req[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_pend_bank.sv
module tmr_pend_bank
    import tmr_evt_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_q
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)              pend_q[g] <= 1'b0;
            else if (set_i[g])    pend_q[g] <= 1'b1;
            else if (clr_i[g])    pend_q[g] <= 1'b0;
        end

        p_set_sticky_r2: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> pend_q[g]);

        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !set_i[g]) |=> !pend_q[g]);

        p_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[g] && !set_i[g]) |=> (pend_q[g] == $past(pend_q[g])));
    end

endmodule

// File: rtl/tmr_dma_gate.sv
module tmr_dma_gate
    import tmr_evt_pkg::*;
(
    input  src_vec_t pend_i,
    input  dma_vec_t dma_en_i,
    input  dma_vec_t dma_ack_i,
    output dma_vec_t dma_req_o,
    output src_vec_t divert_o,
    output src_vec_t dma_clr_o
);

    always_comb begin
        divert_o  = '0;
        dma_clr_o = '0;
        dma_req_o = '0;
        for (int ch = 0; ch < NUM_DMA; ch++) begin
            divert_o[dma_src(ch)]  = dma_en_i[ch];
            dma_clr_o[dma_src(ch)] = dma_ack_i[ch];
            dma_req_o[ch]          = pend_i[dma_src(ch)] & dma_en_i[ch];
        end
    end

endmodule

// File: rtl/tmr_irq_prio.sv
module tmr_irq_prio
    import tmr_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend_i,
    input  src_vec_t mask_i,
    input  src_vec_t divert_i,
    output irq_bus_t irq_o
);

    src_vec_t live;

    always_comb begin
        live      = pend_i & mask_i & ~divert_i;
        irq_o.req = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            irq_o.req[line_of(s)] = irq_o.req[line_of(s)] | live[s];
        end
        irq_o.any = |irq_o.req;
        irq_o.idx = first_line(irq_o.req);
    end

    p_idx_active_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o.any |-> irq_o.req[irq_o.idx]);

    p_top_prio_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o.req[0] |-> (irq_o.idx == '0));

    p_masked_off_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_i == '0) |-> !irq_o.any);

endmodule

// File: rtl/tmr_evt_router.sv
module tmr_evt_router
    import tmr_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] evt_i,
    input  logic [4:0] mask_i,
    input  logic [4:0] ack_i,
    input  logic [1:0] dma_en_i,
    input  logic [1:0] dma_ack_i,
    output logic [4:0] pend_o,
    output logic [2:0] irq_o,
    output logic       irq_any_o,
    output logic [1:0] irq_idx_o,
    output logic [1:0] dma_req_o
);

    src_vec_t pend, divert, dma_clr, clr_all;
    irq_bus_t bus;

    assign clr_all = ack_i | dma_clr;

    tmr_pend_bank #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_i),
        .clr_i  (clr_all),
        .pend_q (pend)
    );

    tmr_dma_gate u_dma (
        .pend_i    (pend),
        .dma_en_i  (dma_en_i),
        .dma_ack_i (dma_ack_i),
        .dma_req_o (dma_req_o),
        .divert_o  (divert),
        .dma_clr_o (dma_clr)
    );

    tmr_irq_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend),
        .mask_i   (mask_i),
        .divert_i (divert),
        .irq_o    (bus)
    );

    assign pend_o    = pend;
    assign irq_o     = bus.req;
    assign irq_any_o = bus.any;
    assign irq_idx_o = bus.idx;

    p_dma_blocks_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o[0] && !pend_o[SRC_CAP1]) |-> !irq_o[1]);

    p_dma_blocks_cmp_r9: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o[1] && !pend_o[SRC_CMP1]) |-> !irq_o[2]);

    p_dma_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (dma_ack_i[0] && !evt_i[SRC_CAP0]) |=> (!pend_o[SRC_CAP0] && !dma_req_o[0]));

    p_set_beats_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_i[SRC_EOC] && ack_i[SRC_EOC]) |=> pend_o[SRC_EOC]);

endmodule

// File: tb/tmr_evt_router_tb_top.sv
module tmr_evt_router_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] evt_i = '0, mask_i = '0, ack_i = '0;
    logic [1:0] dma_en_i = '0, dma_ack_i = '0;
    logic [4:0] pend_o;
    logic [2:0] irq_o;
    logic       irq_any_o;
    logic [1:0] irq_idx_o;
    logic [1:0] dma_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [4:0] m_pend = '0;

    always #2 clk = ~clk;

    tmr_evt_router dut_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .mask_i(mask_i), .ack_i(ack_i),
        .dma_en_i(dma_en_i), .dma_ack_i(dma_ack_i), .pend_o(pend_o),
        .irq_o(irq_o), .irq_any_o(irq_any_o), .irq_idx_o(irq_idx_o),
        .dma_req_o(dma_req_o)
    );

    task automatic model_edge();
        logic [4:0] clr;
        clr = ack_i;
        if (dma_ack_i[0]) clr[1] = 1'b1;
        if (dma_ack_i[1]) clr[3] = 1'b1;
        if (rst) m_pend = '0;
        else     m_pend = (m_pend & ~clr) | evt_i;
    endtask

    task automatic compare(input string tag);
        logic [4:0] live;
        logic [2:0] e_irq;
        logic [1:0] e_dma, e_idx;
        logic       e_any;
        live = m_pend & mask_i;
        if (dma_en_i[0]) live[1] = 1'b0;
        if (dma_en_i[1]) live[3] = 1'b0;
        e_irq[0] = live[0];
        e_irq[1] = live[1] || live[2];
        e_irq[2] = live[3] || live[4];
        e_any    = (e_irq != 3'b000);
        e_idx    = 2'd0;
        if (!e_irq[0] && e_irq[1])                   e_idx = 2'd1;
        else if (!e_irq[0] && !e_irq[1] && e_irq[2]) e_idx = 2'd2;
        e_dma[0] = m_pend[1] && dma_en_i[0];
        e_dma[1] = m_pend[3] && dma_en_i[1];
        checks++;
        if (pend_o !== m_pend || irq_o !== e_irq || irq_any_o !== e_any ||
            irq_idx_o !== e_idx || dma_req_o !== e_dma) begin
            fails++;
            $display("FAIL %s: pend=%b irq=%b any=%b idx=%0d dma=%b expected pend=%b irq=%b any=%b idx=%0d dma=%b",
                     tag, pend_o, irq_o, irq_any_o, irq_idx_o, dma_req_o,
                     m_pend, e_irq, e_any, e_idx, e_dma);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic pulse(input logic [4:0] ev, input logic [4:0] ak,
                         input logic [1:0] dak, input string tag);
        evt_i = ev; ack_i = ak; dma_ack_i = dak;
        cyc(tag);
        evt_i = '0; ack_i = '0; dma_ack_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cyc("R1 reset");
        cyc("R1 reset");
        rst = 1'b0;
        cyc("R1 idle after reset");

        mask_i = 5'b11111;
        pulse(5'b00001, 5'b00000, 2'b00, "R2 eoc sets");
        cyc("R2 sticky");
        cyc("R2 sticky");
        pulse(5'b00000, 5'b11110, 2'b00, "R3 zero bit keeps flag");
        pulse(5'b00000, 5'b00001, 2'b00, "R3 clear");

        mask_i = 5'b00000;
        pulse(5'b11111, 5'b00000, 2'b00, "R5 all latched");
        cyc("R6 masked no irq");
        mask_i = 5'b00100;
        cyc("R6 unmask cap1 raises line1");
        mask_i = 5'b10000;
        cyc("R7 cmp1 on line2");
        mask_i = 5'b11111;
        cyc("R8 line0 wins");
        pulse(5'b00000, 5'b00001, 2'b00, "R8 line1 next");
        pulse(5'b00000, 5'b00110, 2'b00, "R8 line2 next");
        pulse(5'b00000, 5'b11000, 2'b00, "R8 none active");

        pulse(5'b10000, 5'b10000, 2'b00, "R4 set beats clear");
        pulse(5'b00001, 5'b00001, 2'b00, "R4 set beats clear eoc");
        pulse(5'b00000, 5'b11111, 2'b00, "R3 clear all");

        dma_en_i = 2'b11;
        pulse(5'b01010, 5'b00000, 2'b00, "R9 dma diverts");
        cyc("R9 dma request held");
        pulse(5'b00000, 5'b00000, 2'b01, "R10 dma ack ch0");
        pulse(5'b00000, 5'b00000, 2'b10, "R10 dma ack ch1");
        pulse(5'b01010, 5'b00000, 2'b00, "R9 second event");
        dma_en_i = 2'b00;
        cyc("R11 disable routes to irq");
        pulse(5'b00000, 5'b11111, 2'b00, "R3 cleanup");

        for (int n = 0; n < 2000; n++) begin
            if (($urandom % 16) == 0) mask_i = 5'($urandom);
            if (($urandom % 16) == 0) dma_en_i = 2'($urandom);
            evt_i     = 5'($urandom) & 5'($urandom);
            ack_i     = 5'($urandom) & 5'($urandom) & 5'($urandom);
            dma_ack_i = 2'($urandom) & 2'($urandom);
            cyc("R7 random traffic");
        end
        evt_i = '0; ack_i = '0; dma_ack_i = '0;
        rst = 1'b1;
        cyc("R1 reset mid-run");
        finish_run();
    end

endmodule